// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken, given the fetch address of the branch. Two component predictors work side by side. The per-address table holds one 2-bit counter per entry, indexed by the fetch address. The history table holds 2-bit counters indexed by the fetch address XORed with a register of recent branch outcomes. A third table of 2-bit counters, also indexed by address, acts as a referee and decides which component's guess becomes the final answer. Every chooser entry starts out trusting the per-address table, because the history table needs more branches before it gives useful guesses.

The prediction side is purely combinational. An address presented in a cycle yields the final direction, the referee's selection and both component guesses in that same cycle. Fetch logic keeps the two component guesses alongside the branch. When the branch resolves, it returns them on the update side together with the address and the real outcome.

Every counter is a four-state machine: STRONG_LO (00), WEAK_LO (01), WEAK_HI (10) and STRONG_HI (11). There are two transitions. *up* moves one state toward STRONG_HI and stays there once it is reached. *down* moves one state toward STRONG_LO and stays there once it is reached. For the component tables, HI means taken. For the chooser, HI means "use the history table".

Top module: `tournament_pred`

## Requirements
- R1: After reset, every component counter is WEAK_HI (10), every chooser counter is WEAK_LO (01) and the outcome history is zero. Any address therefore predicts taken, using the per-address component.
- R2: The per-address guess comes from the counter at index pc[11:2]. Counter states 10 and 11 mean taken; states 00 and 01 mean not taken.
- R3: The history guess comes from the counter at index pc[11:2] XOR history[9:0]. The same state encoding as R2 applies.
- R4: Each accepted update applies *up* (outcome taken) or *down* (outcome not taken) to both component counters. The counters saturate at 11 and at 00.
- R5: The chooser counter at upd_pc[11:2] changes only when exactly one returned component guess matched the outcome. It moves *up* when the history guess was right and *down* when the per-address guess was right. Chooser bit 1 = 1 selects the history component.
- R6: pred_taken equals the guess of the component that the chooser selects.
- R7: The history is 10 bits wide. On every accepted update it shifts left and the outcome enters bit 0 (1 = taken). The history table index used by an update is formed with the history as it stands before that shift.
- R8: When a prediction reads an entry that an update writes in the same cycle, the prediction returns the value the entry held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | 10 | Fetch address bits 11:2 of the branch to predict |
| pred_taken | output | 1 | Final direction, 1 = taken |
| pred_use_hist | output | 1 | Chooser selection, 1 = history component |
| pred_bim_taken | output | 1 | Per-address component guess |
| pred_hist_taken | output | 1 | History component guess |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 10 | Address bits 11:2 of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_bim_taken | input | 1 | Per-address guess captured at prediction time |
| upd_hist_taken | input | 1 | History guess captured at prediction time |

## Verification
The assertions take the returned component guesses as given. They assume nothing about whether those guesses match what the tables would produce now, because the chooser rule depends only on how each guess compares with the outcome. The chooser-hold property only applies when the same address is predicted in the cycle after an update that carried equal guesses. The bench creates that case on purpose, with directed updates whose guesses are arbitrary. In the mixed phase it returns the guesses its own model produced one cycle earlier, so the update stream looks like a real pipeline with a one-branch lag.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_LO = 2'b00,
        CTR_WEAK_LO   = 2'b01,
        CTR_WEAK_HI   = 2'b10,
        CTR_STRONG_HI = 2'b11
    } ctr_t;

    // one saturating step of a counter state machine
    function automatic ctr_t ctr_step(ctr_t cur, logic up);
        ctr_t nxt;
        nxt = cur;
        unique case (cur)
            CTR_STRONG_LO: nxt = up ? CTR_WEAK_LO   : CTR_STRONG_LO;
            CTR_WEAK_LO:   nxt = up ? CTR_WEAK_HI   : CTR_STRONG_LO;
            CTR_WEAK_HI:   nxt = up ? CTR_STRONG_HI : CTR_WEAK_LO;
            CTR_STRONG_HI: nxt = up ? CTR_STRONG_HI : CTR_WEAK_HI;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
    import tp_pkg::*;
#(
    parameter int   IDX_W   = 10,
    parameter ctr_t INIT    = CTR_WEAK_HI,
    localparam int  ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    ctr_t mem [ENTRIES];

    // state register: one counter machine per entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= INIT;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
        end
    end

    // output: combinational read, sees the pre-write value on a collision
    always_comb begin
        rd_ctr = mem[rd_idx];
    end

endmodule

// File: rtl/tp_hist_reg.sv
module tp_hist_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] hist
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/tournament_pred.sv
module tournament_pred
    import tp_pkg::*;
#(
    parameter int  IDX_W  = 10,
    parameter int  PC_LSB = 2,
    localparam int PC_HI  = PC_LSB + IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_HI:PC_LSB] pred_pc,
    output logic              pred_taken,
    output logic              pred_use_hist,
    output logic              pred_bim_taken,
    output logic              pred_hist_taken,
    input  logic              upd_valid,
    input  logic [PC_HI:PC_LSB] upd_pc,
    input  logic              upd_taken,
    input  logic              upd_bim_taken,
    input  logic              upd_hist_taken
);

    localparam int HIST_W   = IDX_W;
    localparam int TAB_BIM  = 0;
    localparam int TAB_HIST = 1;
    localparam int TAB_CHO  = 2;
    localparam int NUM_TAB  = 3;

    logic [HIST_W-1:0]  ghr_q;
    logic [IDX_W-1:0]   rd_idx [NUM_TAB];
    logic [IDX_W-1:0]   wr_idx [NUM_TAB];
    ctr_t               rd_ctr [NUM_TAB];
    logic [NUM_TAB-1:0] wr_en;
    logic [NUM_TAB-1:0] wr_up;
    logic               bim_ok;
    logic               hist_ok;

    tp_hist_reg #(.W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .bit_in   (upd_taken),
        .hist     (ghr_q)
    );

    // index and training control for the three counter tables
    always_comb begin
        rd_idx[TAB_BIM]  = pred_pc;
        rd_idx[TAB_HIST] = pred_pc ^ ghr_q;
        rd_idx[TAB_CHO]  = pred_pc;
        wr_idx[TAB_BIM]  = upd_pc;
        wr_idx[TAB_HIST] = upd_pc ^ ghr_q;
        wr_idx[TAB_CHO]  = upd_pc;

        bim_ok  = (upd_bim_taken  == upd_taken);
        hist_ok = (upd_hist_taken == upd_taken);

        wr_en[TAB_BIM]  = upd_valid;
        wr_en[TAB_HIST] = upd_valid;
        wr_en[TAB_CHO]  = upd_valid && (bim_ok != hist_ok);
        wr_up[TAB_BIM]  = upd_taken;
        wr_up[TAB_HIST] = upd_taken;
        wr_up[TAB_CHO]  = hist_ok;
    end

    for (genvar g = 0; g < NUM_TAB; g++) begin : g_tab
        tp_ctr_table #(
            .IDX_W (IDX_W),
            .INIT  ((g == TAB_CHO) ? CTR_WEAK_LO : CTR_WEAK_HI)
        ) u_tab (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_idx (rd_idx[g]),
            .rd_ctr (rd_ctr[g]),
            .wr_en  (wr_en[g]),
            .wr_idx (wr_idx[g]),
            .wr_up  (wr_up[g])
        );
    end

    // outputs
    always_comb begin
        pred_bim_taken  = rd_ctr[TAB_BIM][1];
        pred_hist_taken = rd_ctr[TAB_HIST][1];
        pred_use_hist   = rd_ctr[TAB_CHO][1];
        pred_taken      = pred_use_hist ? pred_hist_taken : pred_bim_taken;
    end

endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] pred_pc,
    input logic             pred_taken,
    input logic             pred_use_hist,
    input logic             pred_bim_taken,
    input logic             pred_hist_taken,
    input logic             upd_valid,
    input logic [IDX_W-1:0] upd_pc,
    input logic             upd_taken,
    input logic             upd_bim_taken,
    input logic             upd_hist_taken,
    input logic [IDX_W-1:0] hist
);

    logic seen_upd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         seen_upd <= 1'b0;
        else if (upd_valid) seen_upd <= 1'b1;
    end

    // R1
    reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_upd |-> (!pred_use_hist && pred_bim_taken && pred_hist_taken && pred_taken));

    // R6
    final_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken == (pred_use_hist ? pred_hist_taken : pred_bim_taken));

    // R7
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (hist == {$past(hist[IDX_W-2:0]), $past(upd_taken)}));

    // R7
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(hist));

    // R5
    chooser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (upd_bim_taken == upd_hist_taken) && (pred_pc == upd_pc))
        |=> ((pred_pc != $past(pred_pc)) || (pred_use_hist == $past(pred_use_hist))));

endmodule

bind tournament_pred tp_chk #(.IDX_W(IDX_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pred_pc         (pred_pc),
    .pred_taken      (pred_taken),
    .pred_use_hist   (pred_use_hist),
    .pred_bim_taken  (pred_bim_taken),
    .pred_hist_taken (pred_hist_taken),
    .upd_valid       (upd_valid),
    .upd_pc          (upd_pc),
    .upd_taken       (upd_taken),
    .upd_bim_taken   (upd_bim_taken),
    .upd_hist_taken  (upd_hist_taken),
    .hist            (ghr_q)
);

// File: tb/sim_tournament_pred.sv
`timescale 1ns/1ps
module sim_tournament_pred;

    localparam int N = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] pred_pc = '0;
    logic       pred_taken, pred_use_hist, pred_bim_taken, pred_hist_taken;
    logic       upd_valid = 1'b0;
    logic [9:0] upd_pc = '0;
    logic       upd_taken = 1'b0;
    logic       upd_bim_taken = 1'b0;
    logic       upd_hist_taken = 1'b0;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    int bim_m [N];
    int hst_m [N];
    int cho_m [N];
    int ghr_m;
    int e_b, e_h, e_s, e_t;

    always #10 clk = ~clk;

    tournament_pred u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_use_hist(pred_use_hist), .pred_bim_taken(pred_bim_taken),
        .pred_hist_taken(pred_hist_taken), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_bim_taken(upd_bim_taken), .upd_hist_taken(upd_hist_taken)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sat(int v, bit up);
        if (up) return (v < 3) ? v + 1 : 3;
        return (v > 0) ? v - 1 : 0;
    endfunction

    task automatic model_predict(int pc);
        e_b = (bim_m[pc] >= 2) ? 1 : 0;
        e_h = (hst_m[pc ^ ghr_m] >= 2) ? 1 : 0;
        e_s = (cho_m[pc] >= 2) ? 1 : 0;
        e_t = e_s ? e_h : e_b;
    endtask

    task automatic model_update(int pc, bit t, bit gb, bit gh);
        int hi;
        hi = pc ^ ghr_m;
        bim_m[pc] = sat(bim_m[pc], t);
        hst_m[hi] = sat(hst_m[hi], t);
        if ((gb == t) != (gh == t)) cho_m[pc] = sat(cho_m[pc], gh == t);
        ghr_m = ((ghr_m << 1) | int'(t)) & (N - 1);
    endtask

    // drive one cycle's inputs and compare all outputs with the model
    task automatic step(int pc, bit uv, int upc, bit ut, bit ugb, bit ugh);
        @(negedge clk);
        pred_pc = pc[9:0];
        upd_valid = uv;
        upd_pc = upc[9:0];
        upd_taken = ut;
        upd_bim_taken = ugb;
        upd_hist_taken = ugh;
        #2;
        model_predict(pc);
        chk("R2 R4 per-address guess", int'(pred_bim_taken), e_b);
        chk("R3 R7 history guess", int'(pred_hist_taken), e_h);
        chk("R5 chooser select", int'(pred_use_hist), e_s);
        chk("R6 final direction", int'(pred_taken), e_t);
    endtask

    task automatic tick();
        @(posedge clk);
        if (upd_valid) model_update(int'(upd_pc), upd_taken, upd_bim_taken, upd_hist_taken);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int loopc [8];
        int ppc;
        bit pt, pb, ph, pv;
        for (int i = 0; i < N; i++) begin
            bim_m[i] = 2; hst_m[i] = 2; cho_m[i] = 1;
        end
        ghr_m = 0;
        for (int k = 0; k < 8; k++) loopc[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state seen at the ports
        step(10'h100 >> 2, 0, 0, 0, 0, 0);
        chk("R1 reset direction", int'(pred_taken), 1);
        chk("R1 reset chooser", int'(pred_use_hist), 0);
        tick();

        // R8: same-cycle collision returns the old value
        step(16, 1, 16, 0, 1, 1);
        chk("R8 read before write", int'(pred_bim_taken), 1);
        tick();
        step(16, 0, 0, 0, 0, 0);
        chk("R4 counter moved down", int'(pred_bim_taken), 0);
        tick();

        // R5: history component right twice -> chooser flips to history
        step(32, 1, 32, 0, 1, 0); tick();
        step(32, 1, 32, 0, 1, 0); tick();
        step(32, 0, 0, 0, 0, 0);
        chk("R5 chooser favours history", int'(pred_use_hist), 1);
        tick();
        step(32, 1, 32, 1, 0, 0); tick();
        step(32, 0, 0, 0, 0, 0);
        chk("R5 chooser held when both wrong", int'(pred_use_hist), 1);
        tick();

        // R4: saturation at both ends
        for (int i = 0; i < 4; i++) begin step(48, 1, 48, 0, 0, 0); tick(); end
        step(48, 0, 0, 0, 0, 0);
        chk("R4 saturated low", int'(pred_bim_taken), 0);
        tick();
        step(48, 1, 48, 1, 0, 0); tick();
        step(48, 1, 48, 1, 0, 0); tick();
        step(48, 0, 0, 0, 0, 0);
        chk("R4 two ups from floor", int'(pred_bim_taken), 1);
        tick();

        // mixed stream: each update reports the previous cycle's prediction
        pv = 0; ppc = 0; pt = 0; pb = 0; ph = 0;
        for (int c = 0; c < 4000; c++) begin
            int k, pc;
            bit t;
            k = c % 8;
            if ((c % 13) == 7) k = 2;
            pc = (k * 37 + 5) & (N - 1);
            case (k)
                0: t = 1;
                1: t = 0;
                2: t = ((loopc[k] % 4) != 3);
                3: t = loopc[k][0];
                default: t = $urandom_range(0, 1);
            endcase
            loopc[k]++;
            step(pc, pv, ppc, pt, pb, ph);
            pv = ((c % 11) != 5);
            ppc = pc; pt = t; pb = e_b[0]; ph = e_h[0];
            tick();
        end

        @(negedge clk) upd_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule